// File: doc/BRIEF.md
# Text Screen Fetch Address Generator

This block produces the read addresses a character-mode screen controller needs to pull one frame of text out of a 2 KB display memory. The memory is treated as 16 blocks of 128 bytes. Block 0 holds control bytes: a column-mode bit, a scroll offset for the top screen row, and a table that maps each of the 14 screen rows to the data block that row shows. Each data block holds one row's character bytes, followed by attribute bytes that are each shared by a pair of neighbouring characters.

A frame starts with a read of the scroll byte and then the mode byte. Each row then begins with a table lookup and one idle step, during which the looked-up block is latched. The character walk follows: a character fetch for every column, with an attribute fetch after each even column. Every step is paced by a character-clock enable. The memory answers one cycle after a read. The block tags each fetch as character or attribute. It strobes the end of each row and the end of the frame, and it blanks any row whose table entry points at the control block.

Top module: `text_fetch_addr`

## Requirements
- R1: An address is the 4-bit block number in bits 10:7 and the 7-bit offset in bits 6:0. Each frame opens with a read of block 0 offset 1, then a read of offset 0. Bits 3:0 of offset 1 give the scroll value. Bit 0 of offset 0 selects 72 columns when 1 and 80 columns when 0. All other bits of these bytes are ignored.
- R2: Before screen row r (0 to 13), the block reads block 0 at offset 2 + ((r + scroll) mod 14). Scroll values 14 and 15 wrap the same way. Bits 3:0 of that byte give the row's block number, and bits 7:4 are ignored.
- R3: One step with no memory read separates the table read from the row's first character fetch.
- R4: The character fetch for column c reads offset c of the row's block, with fetch_attr low.
- R5: Directly after the character fetch of each even column c, an attribute fetch reads offset N + c/2 with fetch_attr high, where N is the row length. No attribute fetch follows an odd column.
- R6: A row has 80 columns or 72 columns, as the mode bit selects.
- R7: row_done is high for exactly the one cycle after the step that fetched the last column. frame_done is high in that same cycle for row 13, and the next step starts a new frame.
- R8: A row whose table entry is 0 takes the same steps as any other row, but issues no reads, and row_blank is high during its character and attribute steps.
- R9: A step advances only in a cycle with chr_en high, and mem_rd is high only in such a cycle. Read data is expected on mem_rdata one cycle after the read.
- R10: While rst_n is low, row_done, frame_done, row_blank and fetch_attr are all low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| chr_en | input | 1 | Character-clock enable; one step per high cycle |
| mem_rdata | input | 8 | Read data, valid one cycle after mem_rd |
| mem_addr | output | 11 | Read address {block, offset} |
| mem_rd | output | 1 | Read request for this cycle |
| fetch_attr | output | 1 | High on attribute fetch steps |
| row_blank | output | 1 | High on fetch steps of a blanked row |
| row_done | output | 1 | One-cycle strobe after a row's last column |
| frame_done | output | 1 | One-cycle strobe after row 13 |

## Verification
The bench sweeps complete frames in both column modes. It uses scroll values 0, 13 and 15, so the wrap at 14 and the double wrap are reached. A design that reduced the scroll modulo 16, or that kept the mode byte's upper bits, would read the wrong table entries. The bench mixes back-to-back and irregular chr_en patterns. A design that moved on a cycle with chr_en low, or that used the table byte before the memory had returned it, would fetch from the previous row's block in the first column. Blank rows and the odd last column are compared step by step, so the bench also catches a missing attribute skip, an attribute fetch on odd columns, a row_done one step early, or reads leaking out of a blanked row.

// File: rtl/text_fetch_addr.sv
module text_fetch_addr #(
  parameter int ROWS = 14,
  parameter int COLS_WIDE = 80,
  parameter int COLS_NARROW = 72
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        chr_en,
  input  logic [7:0]  mem_rdata,
  output logic [10:0] mem_addr,
  output logic        mem_rd,
  output logic        fetch_attr,
  output logic        row_blank,
  output logic        row_done,
  output logic        frame_done
);
  localparam int LASTROW = ROWS - 1;

  typedef enum logic [2:0] {ST_SCR, ST_MODE, ST_TBL, ST_GAP, ST_CHR, ST_ATR} st_t;
  typedef enum logic [1:0] {CAP_NONE, CAP_SCR, CAP_MODE, CAP_TBL} cap_t;

  st_t        st;
  cap_t       cap_q;
  logic [3:0] scroll_q, blk_q, row_q;
  logic       narrow_q;
  logic [6:0] col_q;
  logic [6:0] len;
  logic [4:0] sum, idx;
  logic       fetching, last_col;

  assign len      = narrow_q ? 7'(COLS_NARROW) : 7'(COLS_WIDE);
  assign last_col = (col_q == len - 7'd1);
  assign sum      = {1'b0, row_q} + {1'b0, scroll_q};
  assign idx      = (sum >= 5'(2*ROWS)) ? sum - 5'(2*ROWS) :
                    (sum >= 5'(ROWS))   ? sum - 5'(ROWS) : sum;
  assign fetching = (st == ST_CHR) || (st == ST_ATR);

  assign fetch_attr = rst_n && (st == ST_ATR);
  assign row_blank  = rst_n && fetching && (blk_q == 4'd0);
  assign mem_rd     = rst_n && chr_en &&
                      ((st == ST_SCR) || (st == ST_MODE) || (st == ST_TBL) ||
                       (fetching && blk_q != 4'd0));

  always_comb begin
    case (st)
      ST_SCR:  mem_addr = 11'd1;
      ST_MODE: mem_addr = 11'd0;
      ST_TBL:  mem_addr = 11'd2 + {6'd0, idx};
      ST_CHR:  mem_addr = {blk_q, col_q};
      ST_ATR:  mem_addr = {blk_q, len + {1'b0, col_q[6:1]}};
      default: mem_addr = 11'd0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cap_q    <= CAP_NONE;
      scroll_q <= 4'd0;
      narrow_q <= 1'b0;
      blk_q    <= 4'd0;
    end else begin
      case (cap_q)
        CAP_SCR:  scroll_q <= mem_rdata[3:0];
        CAP_MODE: narrow_q <= mem_rdata[0];
        CAP_TBL:  blk_q    <= mem_rdata[3:0];
        default:  ;
      endcase
      if (chr_en && st == ST_SCR)       cap_q <= CAP_SCR;
      else if (chr_en && st == ST_MODE) cap_q <= CAP_MODE;
      else if (chr_en && st == ST_TBL)  cap_q <= CAP_TBL;
      else                              cap_q <= CAP_NONE;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= ST_SCR;
      row_q      <= 4'd0;
      col_q      <= 7'd0;
      row_done   <= 1'b0;
      frame_done <= 1'b0;
    end else begin
      row_done   <= 1'b0;
      frame_done <= 1'b0;
      if (chr_en) begin
        case (st)
          ST_SCR:  begin st <= ST_MODE; row_q <= 4'd0; end
          ST_MODE: st <= ST_TBL;
          ST_TBL:  st <= ST_GAP;
          ST_GAP:  begin st <= ST_CHR; col_q <= 7'd0; end
          ST_CHR: begin
            if (!col_q[0]) st <= ST_ATR;
            else if (last_col) begin
              row_done <= 1'b1;
              if (row_q == 4'(LASTROW)) begin
                frame_done <= 1'b1;
                st <= ST_SCR;
              end else begin
                row_q <= row_q + 4'd1;
                st <= ST_TBL;
              end
            end else col_q <= col_q + 7'd1;
          end
          ST_ATR: begin st <= ST_CHR; col_q <= col_q + 7'd1; end
          default: st <= ST_SCR;
        endcase
      end
    end
  end

  assert_paced_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |-> chr_en);
  assert_blank_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    row_blank |-> !mem_rd);
  assert_attr_span_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd && fetch_attr) |-> (mem_addr[6:0] >= len && mem_addr[6:0] < len + (len >> 1)));
  assert_frame_on_row_R7: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> row_done);
  assert_row_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    row_done |=> !row_done);
  assert_ctrl_in_block0_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd && !fetching) |-> (mem_addr[10:4] == 7'd0));
endmodule

// File: tb/text_fetch_addr_test.sv
module text_fetch_addr_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        chr_en = 1'b0;
  logic [7:0]  mem_rdata = 8'd0;
  logic [10:0] mem_addr;
  logic        mem_rd, fetch_attr, row_blank, row_done, frame_done;

  text_fetch_addr uut (
    .clk(clk), .rst_n(rst_n), .chr_en(chr_en), .mem_rdata(mem_rdata),
    .mem_addr(mem_addr), .mem_rd(mem_rd), .fetch_attr(fetch_attr),
    .row_blank(row_blank), .row_done(row_done), .frame_done(frame_done)
  );

  always #10 clk = ~clk;

  logic [7:0] mem [0:2047];
  always_ff @(posedge clk) if (mem_rd) mem_rdata <= mem[mem_addr];

  int checks = 0, fails = 0;
  bit go = 0, gappy = 0, pend_rd = 0, pend_fd = 0;
  logic [7:0] lf = 8'h5a;

  initial forever begin
    @(posedge clk); #1;
    lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
    chr_en = go && (gappy ? lf[0] : 1'b1);
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic strobes();
    chk(row_done == pend_rd, "R7 row_done", int'(row_done), int'(pend_rd));
    chk(frame_done == pend_fd, "R7 frame_done", int'(frame_done), int'(pend_fd));
    pend_rd = 0;
    pend_fd = 0;
  endtask

  task automatic step(input bit rd, input int addr, input bit attr, input bit blank, input string req);
    do begin
      @(negedge clk);
      strobes();
    end while (!chr_en);
    chk(mem_rd == rd, {req, " mem_rd"}, int'(mem_rd), int'(rd));
    if (rd) chk(int'(mem_addr) == addr, {req, " addr"}, int'(mem_addr), addr);
    chk(fetch_attr == attr, {req, " fetch_attr"}, int'(fetch_attr), int'(attr));
    chk(row_blank == blank, {req, " R8 row_blank"}, int'(row_blank), int'(blank));
  endtask

  task automatic run_frame();
    int n, s;
    n = mem[0][0] ? 72 : 80;
    s = int'(mem[1][3:0]);
    step(1, 1, 0, 0, "R1 scroll read");
    step(1, 0, 0, 0, "R1 mode read");
    for (int r = 0; r < 14; r++) begin
      int idx, b;
      idx = (r + s) % 14;
      b = int'(mem[2 + idx][3:0]);
      step(1, 2 + idx, 0, 0, "R2 table read");
      step(0, 0, 0, 0, "R3 gap");
      for (int c = 0; c < n; c++) begin
        step(b != 0, b * 128 + c, 0, b == 0, "R4 R6 char");
        if (c % 2 == 0) step(b != 0, b * 128 + n + c / 2, 1, b == 0, "R5 attr");
      end
      pend_rd = 1;
      pend_fd = (r == 13);
    end
  endtask

  initial begin
    for (int i = 0; i < 2048; i++) mem[i] = 8'((i * 7) & 255);
    mem[0] = 8'h00; mem[1] = 8'hF0;
    for (int i = 0; i < 14; i++) mem[2 + i] = 8'hA0 | 8'((i == 5) ? 0 : i + 1);
    repeat (4) begin
      @(negedge clk);
      chk(!row_done && !frame_done && !row_blank && !fetch_attr, "R10 reset", 0, 0);
    end
    @(negedge clk); rst_n = 1'b1; go = 1;
    run_frame();
    mem[0] = 8'h03; mem[1] = 8'h0D;
    for (int i = 0; i < 14; i++) mem[2 + i] = 8'h50 | 8'((i == 12) ? 0 : 15 - i);
    gappy = 1;
    run_frame();
    mem[0] = 8'hFE; mem[1] = 8'h0F;
    for (int i = 0; i < 14; i++) mem[2 + i] = 8'hC0 | 8'(i + 1);
    run_frame();
    @(negedge clk);
    strobes();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(20 * 150000);
    checks++; fails++;
    $display("FAIL R7 watchdog expired actual 0 expected 1");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule